// File: doc/BRIEF.md
# Streaming Ones' Complement Checksum

This block computes a 16-bit Internet-style header checksum while the header streams past, one word per clock. Words arrive on a valid/ready interface. Two side-band markers travel with each word: one marks the first word of a packet and one marks the last. Every accepted word is folded into a running ones' complement total. Any carry that leaves the top bit is added back in at the bottom.

When the last word has been taken, the block registers the bitwise inverse of the total as the checksum and raises a one-cycle completion strobe. In the same cycle it reports a pass flag. The flag is high when the total came out as all ones, which is the case when the header already carried a correct checksum field. The block can therefore generate a checksum over a header whose checksum field is zeroed, and it can verify a received header that includes its field.

The block never stalls its source. Header parsing, checksum insertion, byte-wide input and padding of odd lengths are handled elsewhere.

Top module: `csum16_stream`

## Requirements
- R1: `in_ready` is high in every cycle out of reset, and a word is accepted on each rising clock edge where `in_valid` is high.
- R2: Words are summed with ones' complement addition. The carry out of bit 15 is added back into bit 0 on every addition, so 0xFFFF + 0x0001 totals 0x0001 and 0x8000 + 0x8000 totals 0x0001.
- R3: An accepted word with `in_sop` high discards the previous total and starts a new one equal to that word. A packet of a single word (both markers high) therefore gives a checksum equal to the inverse of that word.
- R4: In a cycle with `in_valid` low, the values on `in_data`, `in_sop` and `in_eop` change neither the total nor the outputs.
- R5: `out_done` is high for exactly the one cycle that follows the clock edge that accepts an end-of-packet word, and low in every other cycle.
- R6: `out_csum` equals the bitwise complement of the final total over all the words of the packet. It keeps that value until the next packet's result is registered.
- R7: `out_ok` is high when the final total is 0xFFFF, that is when `out_csum` is zero. It is updated together with `out_csum`.
- R8: While `rst_n` is low at a rising edge, the next cycle shows `out_done` low, `out_csum` zero and `out_ok` low, and the running total is cleared.
- R9: A header that verifies correctly (a 10-word header with its checksum field included) gives `out_ok` low if any one of its 160 bits is flipped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | A word is offered this cycle |
| in_ready | output | 1 | Block can take a word (always high) |
| in_data | input | 16 | Header word |
| in_sop | input | 1 | Word is the first of a packet |
| in_eop | input | 1 | Word is the last of a packet |
| out_done | output | 1 | One-cycle strobe: a result was registered |
| out_csum | output | 16 | Inverse of the final ones' complement total |
| out_ok | output | 1 | Final total was all ones (header verifies) |

## Verification
The properties assume the source frames its words properly. Each packet opens with a start marker and closes with an end marker, and the marker and data pins carry defined values on every cycle, idle cycles included. The single-word check further assumes that a word carrying both markers is a complete packet. The stimulus keeps to these assumptions: every packet, random or directed, is sent with exactly one start and one end marker. Idle cycles are still filled with random data and random marker values. This shows that those pins are ignored whenever valid is low.

// File: rtl/csum_pkg.sv
// Package: shared width default and the accumulator operation code.
// Assumes nothing beyond being compiled before the modules that import it.
package csum_pkg;

    // Default word width of the checksum datapath.
    localparam int unsigned CSUM_W = 16;

    // What the running total does on a given clock edge.
    typedef enum logic [1:0] {
        ACC_HOLD = 2'd0,   // no word accepted
        ACC_LOAD = 2'd1,   // first word of a packet replaces the total
        ACC_ADD  = 2'd2    // word folded into the total
    } acc_op_e;

endpackage

// File: rtl/csum_ones_add.sv
// Module: combinational ones' complement adder of two W-bit operands.
// The carry out of the top bit is added back in at the bottom. For
// operands of W bits this second add can never carry again, so one
// fold is enough.
module csum_ones_add #(
    parameter int unsigned W = csum_pkg::CSUM_W
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] s
);

    localparam int unsigned SUM_W = W + 1;

    logic [SUM_W-1:0] raw;

    // Plain binary add, then wrap the carry back into bit 0.
    always_comb begin
        raw = {1'b0, a} + {1'b0, b};
        s   = raw[W-1:0] + {{(W-1){1'b0}}, raw[W]};
    end

endmodule

// File: rtl/csum_ctrl.sv
// Module: decodes the word handshake into an accumulator operation and a
// finish pulse. Assumes the source never stalls, since ready is constant.
module csum_ctrl
    import csum_pkg::*;
(
    input  logic    in_valid,
    input  logic    in_sop,
    input  logic    in_eop,
    output logic    ready,
    output acc_op_e op,
    output logic    finish
);

    // Ready is constant: one word per clock, no backpressure.
    assign ready = 1'b1;

    // Choose load, add or hold from the accepted word's markers.
    always_comb begin
        op     = ACC_HOLD;
        finish = 1'b0;
        if (in_valid && ready) begin
            op     = in_sop ? ACC_LOAD : ACC_ADD;
            finish = in_eop;
        end
    end

endmodule

// File: rtl/csum_accum.sv
// Module: holds the running ones' complement total. It exposes the
// registered total and the next-state total, so that a result can be
// taken in the same edge that accepts the last word.
// Assumes op is ACC_HOLD whenever no word is accepted.
module csum_accum
    import csum_pkg::*;
#(
    parameter int unsigned W = CSUM_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  acc_op_e      op,
    input  logic [W-1:0] word,
    output logic [W-1:0] total_q,
    output logic [W-1:0] total_d
);

    logic [W-1:0] folded;

    csum_ones_add #(.W(W)) u_add (
        .a (total_q),
        .b (word),
        .s (folded)
    );

    // Next total from the operation code.
    always_comb begin
        unique case (op)
            ACC_LOAD: total_d = word;
            ACC_ADD:  total_d = folded;
            default:  total_d = total_q;
        endcase
    end

    // Total register with synchronous active-low clear.
    always_ff @(posedge clk) begin
        if (!rst_n) total_q <= '0;
        else        total_q <= total_d;
    end

endmodule

// File: rtl/csum_result.sv
// Module: registers the checksum, the pass flag and the done strobe when a
// packet finishes. Assumes final_total is the total including the last
// word.
module csum_result #(
    parameter int unsigned W = csum_pkg::CSUM_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         finish,
    input  logic [W-1:0] final_total,
    output logic         done,
    output logic [W-1:0] csum,
    output logic         ok
);

    // Done pulses for one cycle per finished packet.
    always_ff @(posedge clk) begin
        if (!rst_n) done <= 1'b0;
        else        done <= finish;
    end

    // Checksum and flag load on finish and hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            csum <= '0;
            ok   <= 1'b0;
        end else if (finish) begin
            csum <= ~final_total;
            ok   <= &final_total;
        end
    end

endmodule

// File: rtl/csum16_stream.sv
// Module: streaming ones' complement checksum over a packet of words.
// Takes one word per clock and registers the inverted total, a pass flag
// and a done strobe in the cycle after the end-of-packet word.
// Assumes every packet opens with in_sop and closes with in_eop.
module csum16_stream
    import csum_pkg::*;
#(
    parameter int unsigned W = CSUM_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [W-1:0] in_data,
    input  logic         in_sop,
    input  logic         in_eop,
    output logic         out_done,
    output logic [W-1:0] out_csum,
    output logic         out_ok
);

    acc_op_e      op;
    logic         finish;
    logic [W-1:0] total_q;
    logic [W-1:0] total_d;

    csum_ctrl u_ctrl (
        .in_valid (in_valid),
        .in_sop   (in_sop),
        .in_eop   (in_eop),
        .ready    (in_ready),
        .op       (op),
        .finish   (finish)
    );

    csum_accum #(.W(W)) u_accum (
        .clk     (clk),
        .rst_n   (rst_n),
        .op      (op),
        .word    (in_data),
        .total_q (total_q),
        .total_d (total_d)
    );

    csum_result #(.W(W)) u_result (
        .clk         (clk),
        .rst_n       (rst_n),
        .finish      (finish),
        .final_total (total_d),
        .done        (out_done),
        .csum        (out_csum),
        .ok          (out_ok)
    );

endmodule

// File: rtl/csum16_stream_chk.sv
// Checker: port-level properties of csum16_stream, bound into every instance.
// Assumes defined inputs on every clock and well-framed packets.
module csum16_stream_chk #(
    parameter int unsigned W = csum_pkg::CSUM_W
) (
    input logic         clk,
    input logic         rst_n,
    input logic         in_valid,
    input logic [W-1:0] in_data,
    input logic         in_sop,
    input logic         in_eop,
    input logic         out_done,
    input logic [W-1:0] out_csum,
    input logic         out_ok
);

    // R8
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (!out_done && out_csum == '0 && !out_ok));

    // R5
    done_follows_eop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_eop) |=> out_done);

    // R5
    done_needs_eop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_done |-> $past(in_valid && in_eop));

    // R3
    single_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_sop && in_eop) |=> (out_csum == ~$past(in_data)));

    // R6
    csum_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_done && $past(rst_n)) |-> $stable(out_csum));

    // R7
    ok_matches_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_done |-> (out_ok == (out_csum == '0)));

endmodule

bind csum16_stream csum16_stream_chk #(.W(W)) u_chk (.*);

// File: tb/csum16_stream_tb.sv
module csum16_stream_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [15:0] in_data = '0;
    logic        in_sop = 1'b0;
    logic        in_eop = 1'b0;
    logic        out_done;
    logic [15:0] out_csum;
    logic        out_ok;

    int total = 0;
    int bad = 0;
    bit finished = 0;
    logic [15:0] pkt [0:15];
    logic [15:0] hold_csum;

    always #5 clk = ~clk;

    csum16_stream u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_sop(in_sop), .in_eop(in_eop),
        .out_done(out_done), .out_csum(out_csum), .out_ok(out_ok)
    );

    function automatic logic [15:0] oc_add(input logic [15:0] a, input logic [15:0] b);
        logic [16:0] t;
        t = {1'b0, a} + {1'b0, b};
        return t[15:0] + {15'd0, t[16]};
    endfunction

    function automatic logic [15:0] ref_total(input int n);
        logic [15:0] acc;
        acc = pkt[0];
        for (int i = 1; i < n; i++) acc = oc_add(acc, pkt[i]);
        return acc;
    endfunction

    task automatic check(input bit cond, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        total++;
        if (!cond) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Idle cycle with random junk on the data and marker pins.
    task automatic idle_junk();
        @(negedge clk);
        check(out_done == 1'b0, "R4 idle done", 32'(out_done), 32'd0);
        in_valid = 1'b0;
        in_data  = 16'($urandom);
        in_sop   = 1'($urandom);
        in_eop   = 1'($urandom);
    endtask

    // Send pkt[0..n-1] with optional random gaps, then check the result.
    task automatic send_packet(input int n, input bit gaps);
        logic [15:0] exp_sum;
        exp_sum = ref_total(n);
        for (int i = 0; i < n; i++) begin
            if (gaps && ($urandom % 3 == 0)) idle_junk();
            @(negedge clk);
            check(in_ready == 1'b1, "R1 ready", 32'(in_ready), 32'd1);
            in_valid = 1'b1;
            in_data  = pkt[i];
            in_sop   = (i == 0);
            in_eop   = (i == n - 1);
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_sop   = 1'b0;
        in_eop   = 1'b0;
        check(out_done == 1'b1, "R5 done pulse", 32'(out_done), 32'd1);
        check(out_csum == ~exp_sum, "R6 checksum", 32'(out_csum), 32'(~exp_sum));
        check(out_ok == (exp_sum == 16'hFFFF), "R7 ok flag", 32'(out_ok),
              32'(exp_sum == 16'hFFFF));
        hold_csum = out_csum;
        @(negedge clk);
        check(out_done == 1'b0, "R5 done one cycle", 32'(out_done), 32'd0);
        check(out_csum == hold_csum, "R6 hold", 32'(out_csum), 32'(hold_csum));
    endtask

    task automatic load_header(input bit with_field);
        pkt[0] = 16'h4500; pkt[1] = 16'h0073; pkt[2] = 16'h0000; pkt[3] = 16'h4000;
        pkt[4] = 16'h4011; pkt[5] = with_field ? 16'hB861 : 16'h0000;
        pkt[6] = 16'hC0A8; pkt[7] = 16'h0001; pkt[8] = 16'hC0A8; pkt[9] = 16'h00C7;
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int seed_init;
        seed_init = $urandom(32'h00C5_0A11);
        repeat (3) @(negedge clk);
        // R8: outputs cleared under reset
        check(out_done == 0 && out_csum == 0 && out_ok == 0, "R8 reset state",
              {15'd0, out_done, out_csum}, 32'd0);
        rst_n = 1'b1;

        // R2: end-around carry corner cases
        pkt[0] = 16'hFFFF; pkt[1] = 16'h0001;
        send_packet(2, 0);
        check(out_csum == 16'hFFFE, "R2 carry wrap FFFF+0001", 32'(out_csum), 32'hFFFE);
        pkt[0] = 16'h8000; pkt[1] = 16'h8000;
        send_packet(2, 0);
        check(out_csum == 16'hFFFE, "R2 carry wrap 8000+8000", 32'(out_csum), 32'hFFFE);

        // R3: single-word packet, and a fresh packet discards the old total
        pkt[0] = 16'h1234;
        send_packet(1, 0);
        check(out_csum == 16'hEDCB, "R3 single word", 32'(out_csum), 32'hEDCB);

        // Known header: generate, then verify
        load_header(0);
        send_packet(10, 0);
        check(out_csum == 16'hB861, "R6 header generate", 32'(out_csum), 32'hB861);
        load_header(1);
        send_packet(10, 1);
        check(out_ok == 1'b1, "R7 header verifies", 32'(out_ok), 32'd1);

        // R9: any single bit flip breaks verification
        for (int w = 0; w < 10; w++) begin
            for (int b = 0; b < 16; b++) begin
                load_header(1);
                pkt[w][b] = ~pkt[w][b];
                send_packet(10, 0);
                check(out_ok == 1'b0, "R9 bit flip detected", 32'(out_ok), 32'd0);
            end
        end

        // R4: random packets with junk-filled idle cycles
        for (int p = 0; p < 200; p++) begin
            int n;
            n = 1 + int'($urandom % 12);
            for (int i = 0; i < n; i++) pkt[i] = 16'($urandom);
            send_packet(n, 1);
        end

        // R8: reset in the middle of a packet
        @(negedge clk);
        in_valid = 1'b1; in_data = 16'hAAAA; in_sop = 1'b1; in_eop = 1'b0;
        @(negedge clk);
        rst_n = 1'b0; in_eop = 1'b1;
        @(negedge clk);
        check(out_done == 0 && out_csum == 0 && out_ok == 0, "R8 reset mid packet",
              {15'd0, out_done, out_csum}, 32'd0);
        in_valid = 1'b0; in_eop = 1'b0; in_sop = 1'b0;
        rst_n = 1'b1;
        pkt[0] = 16'h0F0F; pkt[1] = 16'h1010;
        send_packet(2, 0);
        check(out_csum == 16'hE0E0, "R8 clean start after reset", 32'(out_csum), 32'hE0E0);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule